// File: doc/BRIEF.md
# Nibble-Serial DRAM Word Controller

This block sits between a DSP-side word request port and an external DRAM whose data bus is only four bits wide. A single request carries a read or write flag, a 26-bit word address and, for writes, the data word. The controller drives the address in two halves: a row half with the row strobe active, then a column half with both strobes active. It then moves the word one nibble per clock, least significant nibble first. A configuration bit selects 24-bit words, which take six beats, or 16-bit words, which take four.

A free-running refresh timer raises a refresh request at an interval picked by a 3-bit select from eight divider factors. A pending refresh is served before any request that is waiting. It never cuts into an access already in progress. Each refresh is a column-strobe-before-row-strobe cycle with two fixed 2-cycle phases. Reads return the assembled word with a one-cycle valid pulse.

Top module: `nibble_dram_ctrl`

## Requirements
- R1: During and right after reset, `req_ready` is high, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, and `dram_dq_oe` and `rsp_valid` are low.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `dram_addr` carries `req_addr[25:13]`, `dram_ras_n` is low and `dram_cas_n` is high.
- R3: In the next cycle, `dram_addr` carries `req_addr[12:0]` and both strobes are low.
- R4: Data beats follow the column cycle, one per clock with both strobes low. There are 6 beats when `cfg_word24` is 1 at acceptance and 4 when it is 0. After the last beat, both strobes return high.
- R5: On a write, each beat has `dram_dq_oe` high and `dram_we_n` low. Beat k drives `req_wdata[4k+3:4k]`. In 16-bit mode, `req_wdata[23:16]` is never driven.
- R6: On a read, `dram_dq_oe` is low and `dram_we_n` is high. The nibble on `dram_dq_in` at the clock edge ending beat k becomes bits [4k+3:4k] of the word. `rsp_valid` pulses for exactly one cycle, in the cycle after the last beat, and `rsp_rdata` holds the word then. In 16-bit mode, bits [23:16] are zero.
- R7: `req_ready` is low from the cycle after acceptance through the last beat. It is high again in the next cycle when no refresh is pending.
- R8: Refresh cycles start every `DIV_BASE << cfg_rfsh_sel` clock cycles while the bus is otherwise idle.
- R9: A refresh holds `dram_cas_n` low with `dram_ras_n` high for 2 cycles, then holds both low for 2 cycles. Throughout, `dram_we_n` is high and `dram_dq_oe` is low.
- R10: A refresh that falls due during an access does not shorten or alter that access. It runs right after the access ends, before a request that is already waiting, and `req_ready` stays low until the refresh has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word24 | input | 1 | 1: 24-bit words, 0: 16-bit words |
| cfg_rfsh_sel | input | 3 | Refresh divider select |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 26 | Word address |
| req_wdata | input | 24 | Write word |
| rsp_valid | output | 1 | Read word valid, one-cycle pulse |
| rsp_rdata | output | 24 | Assembled read word |
| dram_addr | output | 13 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 4 | Nibble driven to DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Nibble returned by DRAM |

## Verification
The bench builds the block with `DIV_BASE` set to 4 instead of 128. This shrinks the eight refresh intervals to between 4 and 512 cycles, so the interval spacing for several selects can be measured inside a short run. It also lets a refresh be made to fall due at a chosen beat of a running access, which exercises the arbitration against a waiting request. Data and address patterns use the widest address and both word lengths with non-zero unused bytes.

// File: rtl/ndc_pkg.sv
// Shared types for the nibble-serial DRAM controller.
// Assumes: a single clock domain; all users import this package.
package ndc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_DATA,
        ST_RF_CAS,
        ST_RF_RAS
    } ndc_state_t;
endpackage

// File: rtl/ndc_refresh_timer.sv
// Free-running refresh interval timer.
// Raises pend every (DIV_BASE << sel) cycles and holds it until ack.
// Assumes: sel is quasi-static; an expiry in the ack cycle keeps pend set.
module ndc_refresh_timer #(
    parameter int DIV_BASE = 128,
    parameter int CNT_W    = $clog2(DIV_BASE) + 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       ack,
    output logic       pend
);
    logic [CNT_W-1:0] lim [8];
    logic [CNT_W-1:0] cnt;
    logic             expire;

    // Terminal count for each of the eight divider choices.
    for (genvar g = 0; g < 8; g++) begin : g_lim
        assign lim[g] = CNT_W'(DIV_BASE << g) - CNT_W'(1);
    end

    assign expire = (cnt == lim[sel]);

    // Interval counter, restarts on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (expire) cnt <= '0;
        else             cnt <= cnt + CNT_W'(1);
    end

    // Pending flag: set on expiry, cleared when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (expire) pend <= 1'b1;
        else if (ack)    pend <= 1'b0;
    end
endmodule

// File: rtl/ndc_nibble_shift.sv
// Shared word shift register for both directions.
// Load takes the write word; each shift moves out the low nibble and
// takes nib_in at the top, so reads assemble least significant first.
// Assumes: load and shift are never high together.
module ndc_nibble_shift #(
    parameter int WORD_W = 24,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              shift,
    input  logic [NIB_W-1:0]  nib_in,
    output logic [NIB_W-1:0]  nib_out,
    output logic [WORD_W-1:0] word
);
    // Load or shift the word register.
    always_ff @(posedge clk) begin
        if (!rst_n)     word <= '0;
        else if (load)  word <= load_data;
        else if (shift) word <= {nib_in, word[WORD_W-1:NIB_W]};
    end

    assign nib_out = word[NIB_W-1:0];
endmodule

// File: rtl/ndc_sequencer.sv
// Access and refresh sequencer.
// Arbitrates refresh against requests only in idle, then walks
// row, column and data beats, or the two refresh phases.
// Assumes: rfsh_pend stays set until rfsh_ack.
module ndc_sequencer
    import ndc_pkg::*;
#(
    parameter int BEATS_LONG  = 6,
    parameter int BEATS_SHORT = 4,
    parameter int RF_PHASE    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic cfg_long,
    input  logic rfsh_pend,
    output logic req_ready,
    output logic accept,
    output logic rfsh_ack,
    output logic row_phase,
    output logic shift,
    output logic word_long,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic dq_oe,
    output logic rsp_valid
);
    localparam int CMAX = (BEATS_LONG > RF_PHASE) ? BEATS_LONG : RF_PHASE;
    localparam int CW   = $clog2(CMAX) + 1;

    ndc_state_t    state;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic          last_beat;
    logic          phase_end;

    assign last_beat = (cnt == (word_long ? CW'(BEATS_LONG - 1) : CW'(BEATS_SHORT - 1)));
    assign phase_end = (cnt == CW'(RF_PHASE - 1));
    assign req_ready = (state == ST_IDLE) && !rfsh_pend;
    assign accept    = req_ready && req_valid;
    assign rfsh_ack  = (state == ST_IDLE) && rfsh_pend;

    // State, beat/phase counter and latched request attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            wr_q      <= 1'b0;
            word_long <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (rfsh_pend) begin
                        state <= ST_RF_CAS;
                    end else if (req_valid) begin
                        state     <= ST_ROW;
                        wr_q      <= req_write;
                        word_long <= cfg_long;
                    end
                end
                ST_ROW:  state <= ST_COL;
                ST_COL:  state <= ST_DATA;
                ST_DATA: begin
                    if (last_beat) state <= ST_IDLE;
                    cnt <= cnt + CW'(1);
                end
                ST_RF_CAS: begin
                    if (phase_end) begin
                        state <= ST_RF_RAS;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_RF_RAS: begin
                    if (phase_end) state <= ST_IDLE;
                    cnt <= cnt + CW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // One-cycle read completion pulse after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= (state == ST_DATA) && last_beat && !wr_q;
    end

    // Strobe and data-path controls decoded from the state.
    always_comb begin
        row_phase = (state == ST_ROW);
        shift     = (state == ST_DATA);
        ras_n     = !((state == ST_ROW) || (state == ST_COL) ||
                      (state == ST_DATA) || (state == ST_RF_RAS));
        cas_n     = !((state == ST_COL) || (state == ST_DATA) ||
                      (state == ST_RF_CAS) || (state == ST_RF_RAS));
        dq_oe     = (state == ST_DATA) && wr_q;
        we_n      = !dq_oe;
    end
endmodule

// File: rtl/nibble_dram_ctrl.sv
// Top level: DSP word port to a 4-bit-wide DRAM with refresh.
// Holds the request address, muxes row and column onto the DRAM
// address pins and formats the read word for the selected length.
// Assumes: ADDR_W splits into a row half no narrower than the column half.
module nibble_dram_ctrl #(
    parameter int ADDR_W   = 26,
    parameter int NIB_W    = 4,
    parameter int WORD_W   = 24,
    parameter int SHORT_W  = 16,
    parameter int DIV_BASE = 128,
    parameter int RF_PHASE = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_word24,
    input  logic [2:0]                cfg_rfsh_sel,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [WORD_W-1:0]         req_wdata,
    output logic                      rsp_valid,
    output logic [WORD_W-1:0]         rsp_rdata,
    output logic [(ADDR_W+1)/2-1:0]   dram_addr,
    output logic                      dram_ras_n,
    output logic                      dram_cas_n,
    output logic                      dram_we_n,
    output logic [NIB_W-1:0]          dram_dq_out,
    output logic                      dram_dq_oe,
    input  logic [NIB_W-1:0]          dram_dq_in
);
    localparam int ROW_W       = (ADDR_W + 1) / 2;
    localparam int COL_W       = ADDR_W - ROW_W;
    localparam int BEATS_LONG  = WORD_W / NIB_W;
    localparam int BEATS_SHORT = SHORT_W / NIB_W;
    localparam int CNT_W       = $clog2(DIV_BASE) + 8;

    logic              rfsh_pend;
    logic              rfsh_ack;
    logic              accept;
    logic              row_phase;
    logic              shift;
    logic              word_long;
    logic [WORD_W-1:0] word;
    logic [ADDR_W-1:0] addr_q;

    ndc_refresh_timer #(
        .DIV_BASE (DIV_BASE),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_rfsh_sel),
        .ack   (rfsh_ack),
        .pend  (rfsh_pend)
    );

    ndc_sequencer #(
        .BEATS_LONG  (BEATS_LONG),
        .BEATS_SHORT (BEATS_SHORT),
        .RF_PHASE    (RF_PHASE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .cfg_long  (cfg_word24),
        .rfsh_pend (rfsh_pend),
        .req_ready (req_ready),
        .accept    (accept),
        .rfsh_ack  (rfsh_ack),
        .row_phase (row_phase),
        .shift     (shift),
        .word_long (word_long),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (dram_we_n),
        .dq_oe     (dram_dq_oe),
        .rsp_valid (rsp_valid)
    );

    ndc_nibble_shift #(
        .WORD_W (WORD_W),
        .NIB_W  (NIB_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (req_wdata),
        .shift     (shift),
        .nib_in    (dram_dq_in),
        .nib_out   (dram_dq_out),
        .word      (word)
    );

    // Capture the word address on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    // Row half during the row cycle, column half otherwise.
    assign dram_addr = row_phase ? addr_q[ADDR_W-1:COL_W]
                                 : ROW_W'(addr_q[COL_W-1:0]);

    // Short words arrive in the top of the shifter; right-align them.
    assign rsp_rdata = word_long ? word
                                 : WORD_W'(word[WORD_W-1 -: SHORT_W]);
endmodule

// File: rtl/ndc_checker.sv
// Protocol checker for the nibble-serial DRAM controller, bound to the top.
// Assumes: port names of nibble_dram_ctrl; reset is synchronous active-low.
module ndc_checker #(
    parameter int ADDR_W = 26,
    parameter int ROW_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [ROW_W-1:0]  dram_addr,
    input logic              dram_ras_n,
    input logic              dram_cas_n,
    input logic              dram_we_n,
    input logic              dram_dq_oe
);
    // R2: acceptance is followed by the row cycle carrying the row half.
    p_row_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!dram_ras_n && dram_cas_n &&
            dram_addr == $past(req_addr[ADDR_W-1 -: ROW_W])));

    // R7: no second acceptance in the cycle after one.
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: data is driven only inside a write beat.
    p_drive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && !dram_ras_n && !dram_cas_n));

    // R6: the read completion is a single-cycle pulse.
    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: the column-first refresh phase lasts two cycles.
    p_cbr_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && dram_ras_n) |=> (!dram_cas_n && dram_ras_n));

    // R10: no request is taken while any strobe is active.
    p_no_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n || !dram_cas_n) |-> !req_ready);
endmodule

bind nibble_dram_ctrl ndc_checker #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W)
) u_ndc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_dq_oe (dram_dq_oe)
);

// File: tb/nibble_dram_ctrl_test.sv
// Directed bench for nibble_dram_ctrl: one task per scenario.
module nibble_dram_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_word24 = 1'b1;
    logic [2:0]  cfg_rfsh_sel = 3'd7;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic        rsp_valid;
    logic [23:0] rsp_rdata;
    logic [12:0] dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [3:0]  dram_dq_out;
    logic [3:0]  dram_dq_in = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    nibble_dram_ctrl #(.DIV_BASE(4)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_word24(cfg_word24),
        .cfg_rfsh_sel(cfg_rfsh_sel), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string rq,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] sel);
        rst_n = 1'b0;
        req_valid = 1'b0;
        cfg_rfsh_sel = sel;
        dram_dq_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: idle levels after reset.
    task automatic t_reset();
        do_reset(3'd7);
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 1);
        chk({dram_ras_n, dram_cas_n, dram_we_n} === 3'b111, "R1 strobes",
            32'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        chk({dram_dq_oe, rsp_valid} === 2'b00, "R1 oe/rsp",
            32'({dram_dq_oe, rsp_valid}), 0);
    endtask

    // R2..R7: one complete access with per-cycle checks.
    task automatic do_access(input logic wr, input logic w24,
                             input logic [25:0] a, input logic [23:0] d);
        int nb = w24 ? 6 : 4;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; cfg_word24 = w24;
        req_addr = a; req_wdata = d;
        chk(req_ready === 1'b1, "R7 ready before", 32'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!dram_ras_n && dram_cas_n, "R2 row strobes",
            32'({dram_ras_n, dram_cas_n}), 1);
        chk(dram_addr === a[25:13], "R2 row addr", 32'(dram_addr), 32'(a[25:13]));
        chk(req_ready === 1'b0, "R7 busy", 32'(req_ready), 0);
        @(negedge clk);
        chk(!dram_ras_n && !dram_cas_n, "R3 col strobes",
            32'({dram_ras_n, dram_cas_n}), 0);
        chk(dram_addr === a[12:0], "R3 col addr", 32'(dram_addr), 32'(a[12:0]));
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            chk(!dram_ras_n && !dram_cas_n, "R4 beat strobes",
                32'({dram_ras_n, dram_cas_n}), 0);
            chk(req_ready === 1'b0, "R7 busy beat", 32'(req_ready), 0);
            if (wr) begin
                chk(dram_dq_oe && !dram_we_n, "R5 drive", 32'({dram_dq_oe, dram_we_n}), 2);
                chk(dram_dq_out === d[4*k +: 4], "R5 nibble",
                    32'(dram_dq_out), 32'(d[4*k +: 4]));
            end else begin
                chk(!dram_dq_oe && dram_we_n, "R6 no drive",
                    32'({dram_dq_oe, dram_we_n}), 1);
                dram_dq_in = d[4*k +: 4];
            end
        end
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n, "R4 beat count",
            32'({dram_ras_n, dram_cas_n}), 3);
        chk(req_ready === 1'b1, "R7 ready after", 32'(req_ready), 1);
        chk(rsp_valid === !wr, "R6 rsp_valid", 32'(rsp_valid), 32'(!wr));
        if (!wr)
            chk(rsp_rdata === (w24 ? d : {8'h00, d[15:0]}), "R6 rdata",
                32'(rsp_rdata), 32'(w24 ? d : {8'h00, d[15:0]}));
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R6 pulse end", 32'(rsp_valid), 0);
    endtask

    task automatic t_write24();
        do_reset(3'd7);
        do_access(1'b1, 1'b1, 26'h2A5_5A3C, 24'h9E_37C1);
    endtask

    task automatic t_write16();
        do_reset(3'd7);
        do_access(1'b1, 1'b0, 26'h3FF_FFFF, 24'hEE_4D2B);
    endtask

    task automatic t_read24();
        do_reset(3'd7);
        do_access(1'b0, 1'b1, 26'h000_2001, 24'h5B_E0F7);
    endtask

    task automatic t_read16();
        do_reset(3'd7);
        do_access(1'b0, 1'b0, 26'h155_5555, 24'hC3_81A9);
        do_access(1'b1, 1'b1, 26'h0AA_AAAA, 24'h12_3456);
    endtask

    // R8/R9: refresh spacing and phase shape for one select.
    task automatic t_refresh(input logic [2:0] sel);
        int t1, t2;
        int limit;
        do_reset(sel);
        limit = 0;
        do begin @(negedge clk); limit++; end
        while (!(!dram_cas_n && dram_ras_n) && limit < 2000);
        t1 = cyc;
        @(negedge clk);
        chk(!dram_cas_n && dram_ras_n, "R9 cas phase", 32'({dram_ras_n, dram_cas_n}), 2);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(!dram_cas_n && !dram_ras_n && dram_we_n && !dram_dq_oe,
                "R9 ras phase", 32'({dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}), 2);
        end
        @(negedge clk);
        chk(dram_cas_n && dram_ras_n, "R9 end", 32'({dram_ras_n, dram_cas_n}), 3);
        limit = 0;
        do begin @(negedge clk); limit++; end
        while (!(!dram_cas_n && dram_ras_n) && limit < 2000);
        t2 = cyc;
        chk((t2 - t1) == (4 << sel), "R8 interval", 32'(t2 - t1), 32'(4 << sel));
    endtask

    // R10: refresh due mid-access waits, then beats a waiting request.
    task automatic t_priority();
        logic [23:0] d = 24'hA5_C396;
        do_reset(3'd2);
        repeat (11) @(posedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; cfg_word24 = 1'b1;
        req_addr = 26'h1234567; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!dram_ras_n && !dram_cas_n && dram_dq_oe && dram_dq_out === d[4*k +: 4],
                "R10 access intact", 32'(dram_dq_out), 32'(d[4*k +: 4]));
        end
        @(negedge clk);
        chk(req_ready === 1'b0, "R10 ready held", 32'(req_ready), 0);
        @(negedge clk);
        chk(!dram_cas_n && dram_ras_n, "R10 refresh first",
            32'({dram_ras_n, dram_cas_n}), 2);
        repeat (4) @(negedge clk);
        chk(req_ready === 1'b1, "R10 ready after refresh", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!dram_ras_n && dram_cas_n, "R10 waiting req served",
            32'({dram_ras_n, dram_cas_n}), 1);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_write24();
        t_write16();
        t_read24();
        t_read16();
        t_refresh(3'd2);
        t_refresh(3'd4);
        t_refresh(3'd7);
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule